// File: doc/BRIEF.md
# Mode-Gated Periodic Interrupt Timer

This block is a single down-counting periodic interrupt timer placed on a simple register bus. Software loads a 16-bit modulus, selects a power-of-two clock divider and enables the counter. Each time the count passes through zero the block sets an interrupt flag. It then either reloads from the modulus or wraps to all ones. The interrupt request is the flag qualified by an interrupt-enable bit, and the flag is cleared by writing a one to it.

Counting is gated by the system mode. Wait mode leaves the timer running. Stop mode always halts it. Doze and debug modes halt it only when the matching freeze bit in the control register is set. A halted timer keeps its count and divider phase, and it resumes from them when the mode ends. Register writes are accepted while the timer is halted and keep their effect afterwards. Several copies may be placed at a fixed address stride. Each copy decodes a 3-bit local offset.

A small state machine tracks the counter. The states are `ST_IDLE` (enable bit clear), `ST_RUN` (counting) and `ST_FROZEN` (enabled but halted by mode). Every clock it takes one of these transitions:
- `disable`: any state to `ST_IDLE` when the enable bit is 0.
- `freeze`: to `ST_FROZEN` when enabled and a freeze condition holds.
- `thaw`/`start`: to `ST_RUN` when enabled and no freeze condition holds.

The transition is taken from the register and mode values of the current cycle. It therefore acts on counting one cycle later.

Top module: `mgt_timer`

## Requirements
- R1: After reset the control word reads 0x0000, `irq` is 0 and `bus_err` is 0.
- R2: Register offsets are 0 (control), 2 (modulus) and 4 (count, read-only). While counting with the reload bit (control bit 1) set, a divided tick at count 0 sets the flag (control bit 2) and reloads the modulus; any other tick decrements the count.
- R3: With the reload bit clear, a tick at count 0 sets the flag and the count becomes 0xFFFF.
- R4: Control bits 11:8 hold N. The count moves once every 2^N cycles spent in `ST_RUN`.
- R5: Wait mode does not affect counting. Stop mode halts counting and holds the count. A mode change acts on counting from the second clock edge after it.
- R6: In doze mode counting halts only when control bit 5 is 1. After doze ends, counting resumes from the held count.
- R7: In debug mode counting halts only when control bit 4 is 1. Writes made while halted are kept, and counting resumes after debug ends.
- R8: An access with size code 2 (longword) or 3 returns `bus_err` on the next cycle and changes no register. Size code 0 is byte and size code 1 is word.
- R9: An access with `bus_super` = 0 returns `bus_err` on the next cycle and changes no register. An access to offset 6 also returns `bus_err`.
- R10: `irq` equals the flag AND the interrupt-enable bit (control bit 3). Writing 1 to control bit 2 with a word or low-byte access clears the flag, unless a zero tick sets it in the same cycle.
- R11: Control bit 0 is the enable bit. Setting it from 0 loads the count from the modulus. A modulus write while enabled loads the count with the new value at once.
- R12: Read data appears on `bus_rdata` one cycle after the access. A byte access to an even address uses bits 15:8 of the register, and one to an odd address uses bits 7:0. Byte data travels on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| md_wait | input | 1 | System in wait mode |
| md_doze | input | 1 | System in doze mode |
| md_stop | input | 1 | System in stop mode |
| md_dbg | input | 1 | System halted for debug |
| bus_sel | input | 1 | Access strobe for this timer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_super | input | 1 | Access made in supervisor mode |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| bus_addr | input | 3 | Local byte offset |
| bus_wdata | input | 16 | Write data (byte on bits 7:0) |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Registered access-error response |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit registers and a 4-bit divider select. With these values the bench can write a small modulus such as 2 or 3 and see several wrap-arounds within a few dozen cycles. It can also pick divider 2 to show the slowed rate, and load 0x1234 while halted to show a retained write. A behavioural model of the registers, the divider phase and the one-cycle state lag predicts `bus_rdata`, `bus_err` and `irq` on every clock. This puts the reload, wrap-to-0xFFFF, freeze, resume and clear-versus-set collisions under exact cycle checks.

// File: rtl/mgt_pkg.sv
package mgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } mgt_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    localparam logic [1:0] IX_CTRL = 2'd0;
    localparam logic [1:0] IX_MOD  = 2'd1;
    localparam logic [1:0] IX_CNT  = 2'd2;

    localparam int B_EN   = 0;
    localparam int B_RLD  = 1;
    localparam int B_FLAG = 2;
    localparam int B_IE   = 3;
    localparam int B_DBG  = 4;
    localparam int B_DZ   = 5;
    localparam int B_PS   = 8;

endpackage

// File: rtl/mgt_access.sv
module mgt_access
    import mgt_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic             super_i,
    input  logic [1:0]       size,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] ctrl_v,
    input  logic [REG_W-1:0] mod_v,
    input  logic [REG_W-1:0] cnt_v,
    output logic             wr_ctrl,
    output logic             wr_mod,
    output logic             word_acc,
    output logic             lo_lane,
    output logic [REG_W-1:0] rdata,
    output logic             err
);
    localparam int HALF = REG_W / 2;

    logic [1:0]       idx;
    logic             size_ok;
    logic             acc_ok;
    logic [REG_W-1:0] sel_v;
    logic [REG_W-1:0] rd_v;

    assign idx      = addr[2:1];
    assign word_acc = (size == SZ_WORD);
    assign lo_lane  = addr[0];
    assign size_ok  = (size == SZ_BYTE) || (size == SZ_WORD);
    assign acc_ok   = sel && super_i && size_ok && (idx != 2'd3);
    assign wr_ctrl  = acc_ok && wr && (idx == IX_CTRL);
    assign wr_mod   = acc_ok && wr && (idx == IX_MOD);

    always_comb begin
        unique case (idx)
            IX_CTRL: sel_v = ctrl_v;
            IX_MOD:  sel_v = mod_v;
            IX_CNT:  sel_v = cnt_v;
            default: sel_v = '0;
        endcase
        if (word_acc)
            rd_v = sel_v;
        else if (lo_lane)
            rd_v = {{HALF{1'b0}}, sel_v[HALF-1:0]};
        else
            rd_v = {{HALF{1'b0}}, sel_v[REG_W-1:HALF]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= (acc_ok && !wr) ? rd_v : '0;
            err   <= sel && !acc_ok;
        end
    end

    assert_long_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && size == SZ_LONG) |=> err);

    assert_user_rejected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !super_i) |=> (err && rdata == '0));

endmodule

// File: rtl/mgt_prescale.sv
module mgt_prescale #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int PRE_W = (1 << PS_W) - 1;

    generate
        if (PS_W == 0) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            logic [PRE_W-1:0] pre_q;
            logic [31:0]      lim;

            assign lim  = (32'd1 << ps) - 32'd1;
            assign tick = run && (32'(pre_q) >= lim);

            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (clr)
                    pre_q <= '0;
                else if (run)
                    pre_q <= tick ? '0 : pre_q + 1'b1;
            end

            assert_phase_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !clr) |=> $stable(pre_q));
        end
    endgenerate

endmodule

// File: rtl/mgt_fsm.sv
module mgt_fsm
    import mgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       frz,
    output mgt_state_e state_q,
    output logic       run
);
    mgt_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = !en ? ST_IDLE : (frz ? ST_FROZEN : ST_RUN);
            ST_RUN:    state_d = !en ? ST_IDLE : (frz ? ST_FROZEN : ST_RUN);
            ST_FROZEN: state_d = !en ? ST_IDLE : (frz ? ST_FROZEN : ST_RUN);
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_IDLE:   run = 1'b0;
            ST_RUN:    run = 1'b1;
            ST_FROZEN: run = 1'b0;
            default:   run = 1'b0;
        endcase
    end

    assert_freeze_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> (state_q != ST_RUN));

endmodule

// File: rtl/mgt_timer.sv
module mgt_timer
    import mgt_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             md_wait,
    input  logic             md_doze,
    input  logic             md_stop,
    input  logic             md_dbg,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_super,
    input  logic [1:0]       bus_size,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             bus_err,
    output logic             irq
);
    localparam int HALF = REG_W / 2;

    logic             en_q, rld_q, ie_q, dbg_q, dz_q, flag_q;
    logic [PS_W-1:0]  ps_q;
    logic [REG_W-1:0] mod_q, cnt_q, ctrl_v;
    logic [REG_W-1:0] new_ctrl, new_mod;
    logic             wr_ctrl, wr_mod, word_acc, lo_lane;
    logic             frz, run, tick;
    logic             en_rise, mod_ld, ld, flag_set, flag_clr;
    mgt_state_e       state_q;

    function automatic logic [REG_W-1:0] lane_merge(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] wd,
        input logic             word,
        input logic             lo
    );
        if (word)
            return wd;
        else if (lo)
            return {cur[REG_W-1:HALF], wd[HALF-1:0]};
        else
            return {wd[HALF-1:0], cur[HALF-1:0]};
    endfunction

    always_comb begin
        ctrl_v               = '0;
        ctrl_v[B_EN]         = en_q;
        ctrl_v[B_RLD]        = rld_q;
        ctrl_v[B_FLAG]       = flag_q;
        ctrl_v[B_IE]         = ie_q;
        ctrl_v[B_DBG]        = dbg_q;
        ctrl_v[B_DZ]         = dz_q;
        ctrl_v[B_PS +: PS_W] = ps_q;
    end

    mgt_access #(.REG_W(REG_W)) u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .super_i  (bus_super),
        .size     (bus_size),
        .addr     (bus_addr),
        .ctrl_v   (ctrl_v),
        .mod_v    (mod_q),
        .cnt_v    (cnt_q),
        .wr_ctrl  (wr_ctrl),
        .wr_mod   (wr_mod),
        .word_acc (word_acc),
        .lo_lane  (lo_lane),
        .rdata    (bus_rdata),
        .err      (bus_err)
    );

    assign frz = md_stop || (md_doze && dz_q) || (md_dbg && dbg_q);

    mgt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .frz     (frz),
        .state_q (state_q),
        .run     (run)
    );

    assign new_ctrl = lane_merge(ctrl_v, bus_wdata, word_acc, lo_lane);
    assign new_mod  = lane_merge(mod_q, bus_wdata, word_acc, lo_lane);
    assign en_rise  = wr_ctrl && !en_q && new_ctrl[B_EN];
    assign mod_ld   = wr_mod && en_q;
    assign ld       = en_rise || mod_ld;
    assign flag_set = tick && (cnt_q == '0);
    assign flag_clr = wr_ctrl && (word_acc || lo_lane) && bus_wdata[B_FLAG];

    mgt_prescale #(.PS_W(PS_W)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (ld),
        .ps    (ps_q),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rld_q  <= 1'b0;
            ie_q   <= 1'b0;
            dbg_q  <= 1'b0;
            dz_q   <= 1'b0;
            ps_q   <= '0;
            flag_q <= 1'b0;
            mod_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= new_ctrl[B_EN];
                rld_q <= new_ctrl[B_RLD];
                ie_q  <= new_ctrl[B_IE];
                dbg_q <= new_ctrl[B_DBG];
                dz_q  <= new_ctrl[B_DZ];
                ps_q  <= new_ctrl[B_PS +: PS_W];
            end
            if (flag_set)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
            if (wr_mod)
                mod_q <= new_mod;
            if (mod_ld)
                cnt_q <= new_mod;
            else if (en_rise)
                cnt_q <= mod_q;
            else if (tick)
                cnt_q <= (cnt_q == '0) ? (rld_q ? mod_q : '1) : cnt_q - 1'b1;
        end
    end

    assign irq = flag_q && ie_q;

    assert_hold_when_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !ld) |=> $stable(cnt_q));

    assert_flag_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(run && cnt_q == '0));

    assert_mod_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && en_q) |=> (cnt_q == mod_q));

    assert_wait_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (md_wait && en_q && !frz && !wr_ctrl) |=> (state_q == ST_RUN));

endmodule

// File: tb/mgt_timer_bench.sv
module mgt_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        md_wait = 1'b0, md_doze = 1'b0, md_stop = 1'b0, md_dbg = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_super = 1'b1;
    logic [1:0]  bus_size = 2'd1;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mgt_timer u_mgt_timer (
        .clk(clk), .rst_n(rst_n),
        .md_wait(md_wait), .md_doze(md_doze), .md_stop(md_stop), .md_dbg(md_dbg),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_super(bus_super),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_en, m_rld, m_ie, m_dbg, m_dz, m_ps, m_flag, m_mod, m_cnt, m_pre, m_st;
    int e_rdata, e_err, e_irq;

    function automatic int mrg(int cur, int d, bit word, bit lo);
        if (word) return d & 16'hFFFF;
        if (lo) return (cur & 16'hFF00) | (d & 8'hFF);
        return ((d & 8'hFF) << 8) | (cur & 8'hFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_rld = 0; m_ie = 0; m_dbg = 0; m_dz = 0; m_ps = 0;
            m_flag = 0; m_mod = 0; m_cnt = 0; m_pre = 0; m_st = 0;
            e_rdata = 0; e_err = 0; e_irq = 0;
        end else begin
            int idx, cv, v, nc, nm, lim, st_n;
            bit ok, word, lo, wc, wm, frz, tick, rise, mld, fset, fclr;
            idx  = int'(bus_addr[2:1]);
            lo   = bus_addr[0];
            word = (bus_size == 2'd1);
            ok   = bus_sel && bus_super && (bus_size < 2'd2) && (idx != 3);
            cv   = m_en | (m_rld << 1) | (m_flag << 2) | (m_ie << 3) |
                   (m_dbg << 4) | (m_dz << 5) | (m_ps << 8);
            v    = (idx == 0) ? cv : (idx == 1) ? m_mod : m_cnt;
            e_rdata = (ok && !bus_wr) ? (word ? v : (lo ? (v & 255) : ((v >> 8) & 255))) : 0;
            e_err   = bus_sel && !ok;
            wc   = ok && bus_wr && idx == 0;
            wm   = ok && bus_wr && idx == 1;
            nc   = mrg(cv, int'(bus_wdata), word, lo);
            nm   = mrg(m_mod, int'(bus_wdata), word, lo);
            frz  = md_stop || (md_doze && m_dz != 0) || (md_dbg && m_dbg != 0);
            lim  = (1 << m_ps) - 1;
            tick = (m_st == 1) && (m_pre >= lim);
            rise = wc && m_en == 0 && (nc & 1) != 0;
            mld  = wm && m_en != 0;
            fset = tick && m_cnt == 0;
            fclr = wc && (word || lo) && bus_wdata[2];
            st_n = (m_en == 0) ? 0 : (frz ? 2 : 1);
            if (mld) m_cnt = nm;
            else if (rise) m_cnt = m_mod;
            else if (tick) m_cnt = (m_cnt == 0) ? ((m_rld != 0) ? m_mod : 16'hFFFF) : m_cnt - 1;
            if (rise || mld) m_pre = 0;
            else if (m_st == 1) m_pre = tick ? 0 : m_pre + 1;
            m_st = st_n;
            if (fset) m_flag = 1;
            else if (fclr) m_flag = 0;
            if (wc) begin
                m_en = nc & 1; m_rld = (nc >> 1) & 1; m_ie = (nc >> 3) & 1;
                m_dbg = (nc >> 4) & 1; m_dz = (nc >> 5) & 1; m_ps = (nc >> 8) & 15;
            end
            if (wm) m_mod = nm;
            e_irq = m_flag & m_ie;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R12 rdata vs model", int'(bus_rdata), e_rdata);
            check("R8 bus_err vs model", int'(bus_err), e_err);
            check("R10 irq vs model", int'(irq), e_irq);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic acc(input logic w, input logic [2:0] a, input logic [1:0] sz,
                       input logic [15:0] d, input logic sup,
                       output logic [15:0] rd, output logic er);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_size = sz;
        bus_wdata = d; bus_super = sup;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_super = 1'b1;
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] r; logic e;
        acc(1'b1, a, 2'd1, d, 1'b1, r, e);
    endtask

    task automatic rd16(input logic [2:0] a, output int v);
        logic [15:0] r; logic e;
        acc(1'b0, a, 2'd1, 16'd0, 1'b1, r, e);
        v = int'(r);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int v, c0, c1;
        logic [15:0] r;
        logic e;
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd16(3'd0, v);
        check("R1 ctrl after reset", v, 16'h0000);
        check("R1 irq after reset", int'(irq), 0);
        check("R1 bus_err after reset", int'(bus_err), 0);

        // R2: periodic reload, modulus 3
        wr16(3'd2, 16'd3);
        rd16(3'd2, v);
        check("R2 modulus readback", v, 3);
        wr16(3'd0, 16'h000B);
        idle(30);
        check("R2 irq after wrap", int'(irq), 1);
        rd16(3'd4, v);
        check("R2 count within modulus", int'(v <= 3), 1);

        // R10: gating and write-one-to-clear
        wr16(3'd0, 16'h0003);
        check("R10 irq masked by enable bit", int'(irq), 0);
        rd16(3'd0, v);
        check("R10 flag still set", int'((v & 4) != 0), 1);
        md_dbg = 1'b1;
        wr16(3'd0, 16'h0013);
        idle(3);
        wr16(3'd0, 16'h0017);
        rd16(3'd0, v);
        check("R10 flag cleared by W1C", v, 16'h0013);

        // R7: debug freeze, retained writes
        rd16(3'd4, c0);
        idle(20);
        rd16(3'd4, c1);
        check("R7 count held in debug", c1, c0);
        wr16(3'd2, 16'h1234);
        rd16(3'd4, v);
        check("R11 modulus write loads count", v, 16'h1234);
        rd16(3'd2, v);
        check("R7 write in debug retained", v, 16'h1234);
        @(negedge clk) md_dbg = 1'b0;
        idle(10);
        rd16(3'd4, v);
        check("R7 counting resumes after debug", int'(v < 16'h1234 && v > 16'h1234 - 20), 1);

        // R6: doze
        md_doze = 1'b1;
        rd16(3'd4, c0); idle(5); rd16(3'd4, c1);
        check("R6 doze without freeze bit counts", int'(c1 != c0), 1);
        wr16(3'd0, 16'h0033);
        idle(2);
        rd16(3'd4, c0); idle(10); rd16(3'd4, c1);
        check("R6 doze with freeze bit holds", c1, c0);
        @(negedge clk) md_doze = 1'b0;
        idle(5);
        rd16(3'd4, c1);
        check("R6 resume after doze", int'(c1 != c0 && c1 < c0), 1);

        // R5: wait and stop
        md_wait = 1'b1;
        rd16(3'd4, c0); idle(5); rd16(3'd4, c1);
        check("R5 wait mode counts", int'(c1 != c0), 1);
        md_wait = 1'b0;
        md_stop = 1'b1;
        idle(2);
        rd16(3'd4, c0); idle(10); rd16(3'd4, c1);
        check("R5 stop holds count", c1, c0);

        // R8: longword and reserved size
        acc(1'b1, 3'd0, 2'd2, 16'h0000, 1'b1, r, e);
        check("R8 longword write error", int'(e), 1);
        rd16(3'd0, v);
        check("R8 ctrl unchanged", v, 16'h0033);
        acc(1'b0, 3'd2, 2'd2, 16'h0000, 1'b1, r, e);
        check("R8 longword read error", int'(e), 1);
        acc(1'b0, 3'd2, 2'd3, 16'h0000, 1'b1, r, e);
        check("R8 size 3 error", int'(e), 1);

        // R9: user mode and unmapped offset
        acc(1'b1, 3'd2, 2'd1, 16'h0000, 1'b0, r, e);
        check("R9 user write error", int'(e), 1);
        rd16(3'd2, v);
        check("R9 modulus unchanged", v, 16'h1234);
        acc(1'b0, 3'd6, 2'd1, 16'h0000, 1'b1, r, e);
        check("R9 offset 6 error", int'(e), 1);

        // R12: byte lanes
        acc(1'b1, 3'd3, 2'd0, 16'h0056, 1'b1, r, e);
        acc(1'b0, 3'd2, 2'd0, 16'h0000, 1'b1, r, e);
        check("R12 high byte read", int'(r), 16'h0012);
        acc(1'b0, 3'd3, 2'd0, 16'h0000, 1'b1, r, e);
        check("R12 low byte read", int'(r), 16'h0056);
        acc(1'b1, 3'd2, 2'd0, 16'h00AB, 1'b1, r, e);
        rd16(3'd2, v);
        check("R12 high byte write", v, 16'hAB56);

        // R3: no reload wraps to 0xFFFF
        @(negedge clk) md_stop = 1'b0;
        wr16(3'd0, 16'h0000);
        wr16(3'd2, 16'd2);
        wr16(3'd0, 16'h0009);
        idle(10);
        check("R3 irq after zero", int'(irq), 1);
        rd16(3'd4, v);
        check("R3 count wrapped to top", int'(v >= 16'hFFF0), 1);

        // R4: prescaler N=2
        wr16(3'd0, 16'h0004);
        wr16(3'd2, 16'h0100);
        acc(1'b1, 3'd0, 2'd0, 16'h0002, 1'b1, r, e);
        acc(1'b1, 3'd1, 2'd0, 16'h0001, 1'b1, r, e);
        rd16(3'd0, v);
        check("R4 divider field readback", v, 16'h0201);
        idle(40);
        rd16(3'd4, v);
        check("R4 count rate divided by 4", int'((16'h0100 - v) >= 9 && (16'h0100 - v) <= 12), 1);
        idle(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule